// File: doc/BRIEF.md
# LPC Single-Byte Write Target

This block is the target side of a Low Pin Count style bus, which carries everything over four shared wires. It handles only write cycles that carry one byte. On every rising clock edge it samples the 4-bit bus value and the active-low frame strobe. From these it recognises a start nibble, checks the cycle type and direction, collects a 32-bit address and one data byte, and then completes the turnaround and sync handshake that returns the bus to the host. A complete cycle lasts 17 clocks.

Clock k of a cycle is the period that ends at rising edge k, where edge 1 is the edge that samples the start nibble. A host nibble for clock k is sampled at edge k. A target nibble for clock k is registered at edge k-1 and held until edge k. The target never drives the wires directly. It presents an output value together with an output enable, and the pad logic combines the two.

An accepted write comes out on a plain one-clock strobe, together with the address, the data byte and a memory-or-register select. There is no ready input and no back-pressure. The bus protocol cannot stall a finished write, so the consumer must take the fields in the clock in which the strobe is high. Outside that clock, all of these fields read zero.

Top module: `lpc_wr_engine`

## Requirements
- R1: A synchronous active-low reset returns the engine to idle within one clock. While reset is applied, `lad_oe` and `wr_valid` stay low.
- R2: A cycle starts only at an edge where `lframe_n` is 0 and `lad_in` is 4'b0000. A 0000 nibble with `lframe_n` high, or `lframe_n` low with any other nibble, starts nothing.
- R3: The nibble at edge 2 must have bits [3:2] = 2'b01 and bit 1 = 1 (write). Bit 0 has no effect. Any other value abandons the cycle, and `lad_oe` stays low until a new start.
- R4: Edges 3 to 10 carry the address, most significant nibble first. At edge 3, `lad_in` supplies address bits [31:28], and at edge 10 it supplies bits [3:0].
- R5: Address bits [31:23] must all be 1. If any of them is 0, the cycle is abandoned with no strobe and `lad_oe` stays low.
- R6: `wr_mem_sel` equals address bit 22 in the strobe clock: 1 for a memory access, 0 for a register access.
- R7: Edges 11 and 12 carry the data byte, least significant nibble first. Edge 11 supplies `wr_data[3:0]` and edge 12 supplies `wr_data[7:4]`.
- R8: `lad_oe` is low through clock 13, when the host drives the turnaround nibble. In clock 14, `lad_oe` is high and `lad_out` is 4'b1111.
- R9: In clock 15, `lad_out` is 4'b0000 with `lad_oe` high. `wr_valid` is high for exactly that one clock, with the address, data and select valid. Outside that clock, `wr_valid`, `wr_addr`, `wr_data` and `wr_mem_sel` are 0.
- R10: In clock 16, `lad_out` is 4'b1111 with `lad_oe` high. In clock 17, `lad_oe` is low again. A new start is accepted as early as edge 17.
- R11: At any edge after the start where `lframe_n` is 0, the current cycle is dropped and gives no strobe. If `lad_in` is 0000 at that edge, a new cycle starts from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every field is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lad_in | input | 4 | Sampled value of the four shared bus wires |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_out | output | 4 | Nibble the target presents while it owns the bus |
| lad_oe | output | 1 | High while the target drives the bus wires |
| wr_valid | output | 1 | One-clock strobe for an accepted write |
| wr_addr | output | 32 | Address of the accepted write, zero outside the strobe |
| wr_data | output | 8 | Data byte of the accepted write, zero outside the strobe |
| wr_mem_sel | output | 1 | 1 for a memory access, 0 for a register access, zero outside the strobe |

## Verification
Every result is tied to the edge counter of the cycle. The drive enable rises in the clock right after the host turnaround is sampled at edge 13. The sync nibble and the write strobe appear one clock later, after edge 14. The closing turnaround follows after edge 15, and the wires are released after edge 16. An abort shows its effect in the clock right after the edge that samples the low frame strobe.

The bench holds a behavioural model that counts sampled nibbles since the last start. It updates at the same rising edge as the design and compares every output at the following falling edge. Because of this, no check can be early or late by a clock. Directed checks also step through clocks 13 to 17 one at a time.

// File: rtl/lpc_wr_pkg.sv
package lpc_wr_pkg;

  // Phase of the target; each value names what the next sampled edge carries.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CTYPE = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DATA  = 3'd3,
    PH_HTURN = 3'd4,
    PH_TTURN = 3'd5,
    PH_READY = 3'd6,
    PH_TEND  = 3'd7
  } lpc_phase_e;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_TURN  = 4'b1111;
  localparam logic [1:0] CT_CLASS  = 2'b01;
  localparam logic       CT_DIR_WR = 1'b1;

endpackage

// File: rtl/lpc_wr_seq.sv
// Cycle sequencer: walks the nibble positions of one write and handles abort.
module lpc_wr_seq
  import lpc_wr_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter int DATA_NIBBLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lad_in,
  input  logic       lframe_n,
  input  logic       prefix_ok,
  output lpc_phase_e phase,
  output logic       addr_shift,
  output logic       data_shift,
  output logic       restart
);

  localparam int CW = (ADDR_NIBBLES > 1) ? $clog2(ADDR_NIBBLES) : 1;
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_NIBBLES - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_NIBBLES - 1);

  lpc_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    addr_shift = 1'b0;
    data_shift = 1'b0;
    restart    = 1'b0;
    if (!lframe_n) begin
      // Frame low always re-arms: either a fresh start or back to idle.
      cnt_d = '0;
      if (lad_in == NIB_START) begin
        phase_d = PH_CTYPE;
        restart = 1'b1;
      end else begin
        phase_d = PH_IDLE;
      end
    end else begin
      case (phase_q)
        PH_IDLE: phase_d = PH_IDLE;
        PH_CTYPE: begin
          if (lad_in[3:2] == CT_CLASS && lad_in[1] == CT_DIR_WR) begin
            phase_d = PH_ADDR;
          end else begin
            phase_d = PH_IDLE;
          end
        end
        PH_ADDR: begin
          addr_shift = 1'b1;
          if (cnt_q == ADDR_LAST) begin
            cnt_d   = '0;
            phase_d = prefix_ok ? PH_DATA : PH_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          data_shift = 1'b1;
          if (cnt_q == DATA_LAST) begin
            cnt_d   = '0;
            phase_d = PH_HTURN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_HTURN: phase_d = PH_TTURN;
        PH_TTURN: phase_d = PH_READY;
        PH_READY: phase_d = PH_TEND;
        PH_TEND:  phase_d = PH_IDLE;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/lpc_wr_capture.sv
// Field capture: address shifts in top-first, data shifts in bottom-first.
module lpc_wr_capture #(
  parameter int ADDR_NIBBLES = 8,
  parameter int DATA_NIBBLES = 2,
  parameter int PREFIX_LSB   = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                lad_in,
  input  logic                      clear,
  input  logic                      addr_shift,
  input  logic                      data_shift,
  output logic [4*ADDR_NIBBLES-1:0] addr_q,
  output logic [4*DATA_NIBBLES-1:0] data_q,
  output logic                      prefix_ok
);

  localparam int AW = 4 * ADDR_NIBBLES;
  localparam int DW = 4 * DATA_NIBBLES;

  // Before the last address nibble enters, the final bits [AW-1:PREFIX_LSB]
  // sit four places lower in the shift register.
  assign prefix_ok = &addr_q[AW-5:PREFIX_LSB-4];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      addr_q <= '0;
    end else if (addr_shift) begin
      addr_q <= {addr_q[AW-5:0], lad_in};
    end
  end

  generate
    if (DW == 4) begin : g_data_one
      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          data_q <= '0;
        end else if (data_shift) begin
          data_q <= lad_in;
        end
      end
    end else begin : g_data_many
      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          data_q <= '0;
        end else if (data_shift) begin
          data_q <= {lad_in, data_q[DW-1:4]};
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lpc_wr_drive.sv
// Bus-side drive decode from the registered phase.
module lpc_wr_drive
  import lpc_wr_pkg::*;
(
  input  lpc_phase_e phase,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  output logic       strobe
);

  always_comb begin
    lad_out = NIB_TURN;
    lad_oe  = 1'b0;
    strobe  = 1'b0;
    case (phase)
      PH_TTURN: lad_oe = 1'b1;
      PH_READY: begin
        lad_oe  = 1'b1;
        lad_out = NIB_READY;
        strobe  = 1'b1;
      end
      PH_TEND:  lad_oe = 1'b1;
      default:  lad_oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/lpc_wr_engine.sv
module lpc_wr_engine
  import lpc_wr_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter int DATA_NIBBLES = 2,
  parameter int PREFIX_LSB   = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                lad_in,
  input  logic                      lframe_n,
  output logic [3:0]                lad_out,
  output logic                      lad_oe,
  output logic                      wr_valid,
  output logic [4*ADDR_NIBBLES-1:0] wr_addr,
  output logic [4*DATA_NIBBLES-1:0] wr_data,
  output logic                      wr_mem_sel
);

  localparam int ADDR_W = 4 * ADDR_NIBBLES;
  localparam int DATA_W = 4 * DATA_NIBBLES;

  lpc_phase_e        phase;
  logic              addr_shift, data_shift, restart, prefix_ok, strobe;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  lpc_wr_seq #(
    .ADDR_NIBBLES(ADDR_NIBBLES),
    .DATA_NIBBLES(DATA_NIBBLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lad_in    (lad_in),
    .lframe_n  (lframe_n),
    .prefix_ok (prefix_ok),
    .phase     (phase),
    .addr_shift(addr_shift),
    .data_shift(data_shift),
    .restart   (restart)
  );

  lpc_wr_capture #(
    .ADDR_NIBBLES(ADDR_NIBBLES),
    .DATA_NIBBLES(DATA_NIBBLES),
    .PREFIX_LSB  (PREFIX_LSB)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .lad_in    (lad_in),
    .clear     (restart),
    .addr_shift(addr_shift),
    .data_shift(data_shift),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .prefix_ok (prefix_ok)
  );

  lpc_wr_drive u_drv (
    .phase  (phase),
    .lad_out(lad_out),
    .lad_oe (lad_oe),
    .strobe (strobe)
  );

  assign wr_valid   = strobe;
  assign wr_addr    = strobe ? addr_q : '0;
  assign wr_data    = strobe ? data_q : '0;
  assign wr_mem_sel = strobe & addr_q[PREFIX_LSB-1];

endmodule

// File: rtl/lpc_wr_engine_chk.sv
module lpc_wr_engine_chk #(
  parameter int PW = 9,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lframe_n,
  input logic [3:0]    lad_out,
  input logic          lad_oe,
  input logic          wr_valid,
  input logic [PW-1:0] wr_prefix,
  input logic [DW-1:0] wr_data
);

  // R1: reset leaves the wires released and no strobe
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!lad_oe && !wr_valid));

  // R9: strobe never lasts two clocks
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R9: strobe coincides with the driven sync nibble
  a_r9_sync_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (lad_oe && lad_out == 4'b0000));

  // R9: data field is quiet outside the strobe
  a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (wr_data == '0));

  // R8: first driven clock carries the turnaround nibble
  a_r8_first_turn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (lad_out == 4'b1111));

  // R10: the target owns the wires for at most three clocks
  a_r10_drive_span: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && $past(lad_oe) && $past(lad_oe, 2)) |=> !lad_oe);

  // R11: a low frame strobe cancels any pending strobe
  a_r11_abort_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> !wr_valid);

  // R5: only addresses with the full prefix are issued
  a_r5_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (&wr_prefix));

endmodule

bind lpc_wr_engine lpc_wr_engine_chk #(
  .PW(4 * ADDR_NIBBLES - PREFIX_LSB),
  .DW(4 * DATA_NIBBLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lframe_n (lframe_n),
  .lad_out  (lad_out),
  .lad_oe   (lad_oe),
  .wr_valid (wr_valid),
  .wr_prefix(wr_addr[4*ADDR_NIBBLES-1:PREFIX_LSB]),
  .wr_data  (wr_data)
);

// File: tb/lpc_wr_engine_tb.sv
`timescale 1ns/1ps
module lpc_wr_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lad_in = 4'hF;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_mem_sel;

  always #2.5 clk = ~clk;

  lpc_wr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .lad_in(lad_in), .lframe_n(lframe_n),
    .lad_out(lad_out), .lad_oe(lad_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_mem_sel(wr_mem_sel)
  );

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    running = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Reference model: nibble count since the last start and the nibbles seen.
  int mpos = 0;
  int mq[$];

  function automatic logic [31:0] model_addr();
    logic [31:0] a = '0;
    for (int i = 2; i < 10; i++) a = {a[27:0], 4'(mq[i])};
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mpos = 0;
      mq.delete();
    end else if (!lframe_n) begin
      mq.delete();
      if (lad_in == 4'b0000) begin
        mpos = 1;
        mq.push_back(0);
      end else begin
        mpos = 0;
      end
    end else if (mpos > 0) begin
      mq.push_back(int'(lad_in));
      mpos++;
      if (mpos == 2 && !(lad_in[3:2] == 2'b01 && lad_in[1])) mpos = 0;
      else if (mpos == 10 && model_addr() < 32'hFF80_0000) mpos = 0;
      else if (mpos == 16) mpos = 0;
    end
  end

  // Per-clock comparison, half a clock after the model and design update.
  int          nstrobe = 0;
  int          noe = 0;
  logic [31:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic        last_sel = 1'b0;

  always @(negedge clk) begin
    if (wr_valid === 1'b1) begin
      nstrobe++;
      last_addr = wr_addr;
      last_data = wr_data;
      last_sel  = wr_mem_sel;
    end
    if (lad_oe === 1'b1) noe++;
    if (running) begin
      logic        e_oe, e_v;
      logic [31:0] e_a;
      logic [7:0]  e_d;
      e_oe = (mpos >= 13 && mpos <= 15);
      e_v  = (mpos == 14);
      e_a  = e_v ? model_addr() : 32'h0;
      e_d  = e_v ? {4'(mq[11]), 4'(mq[10])} : 8'h0;
      chk(lad_oe === e_oe, "lad_oe", 32'(lad_oe), 32'(e_oe));
      if (e_oe) chk(lad_out === (e_v ? 4'h0 : 4'hF), "lad_out",
                    32'(lad_out), e_v ? 32'h0 : 32'hF);
      chk(wr_valid === e_v, "wr_valid", 32'(wr_valid), 32'(e_v));
      chk(wr_addr === e_a, "wr_addr", wr_addr, e_a);
      chk(wr_data === e_d, "wr_data", 32'(wr_data), 32'(e_d));
      chk(wr_mem_sel === (e_v & e_a[22]), "wr_mem_sel",
          32'(wr_mem_sel), 32'(e_v & e_a[22]));
    end
  end

  task automatic slot(input logic lf, input logic [3:0] nib);
    @(negedge clk);
    lframe_n = lf;
    lad_in   = nib;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 4'hF);
  endtask

  // Drives positions first..last of one write; abort_at replaces that slot.
  task automatic lpc_write(input logic [3:0] ct, input logic [31:0] addr,
                           input logic [7:0] data, input int first,
                           input int last, input int abort_at,
                           input logic [3:0] abort_nib);
    for (int p = first; p <= last; p++) begin
      if (p == abort_at) begin
        slot(1'b0, abort_nib);
        return;
      end
      if (p == 1) slot(1'b0, 4'h0);
      else if (p == 2) slot(1'b1, ct);
      else if (p <= 10) slot(1'b1, addr[(10-p)*4 +: 4]);
      else if (p == 11) slot(1'b1, data[3:0]);
      else if (p == 12) slot(1'b1, data[7:4]);
      else slot(1'b1, 4'hF);
    end
  endtask

  task automatic expect_write(input int n0, input logic [31:0] a,
                              input logic [7:0] d, input logic sel);
    chk(nstrobe == n0 + 1, "strobe count", 32'(nstrobe), 32'(n0 + 1));
    chk(last_addr == a, "address", last_addr, a);
    chk(last_data == d, "data", 32'(last_data), 32'(d));
    chk(last_sel == sel, "mem select", 32'(last_sel), 32'(sel));
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    finish_up();
  end

  initial begin
    int n0, o0;
    // R1: reset state
    tag = "R1";
    running = 1'b1;
    idle(3);
    chk(lad_oe === 1'b0, "oe in reset", 32'(lad_oe), 0);
    chk(wr_valid === 1'b0, "valid in reset", 32'(wr_valid), 0);
    rst_n = 1'b1;
    idle(2);

    // R4 R6 R7 R9: memory write
    tag = "R4/R7 memory write";
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFFC1_2A5C, 8'hA7, 1, 17, 0, 4'h0);
    expect_write(n0, 32'hFFC1_2A5C, 8'hA7, 1'b1);

    // R6: register write
    tag = "R6 register write";
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFF80_0010, 8'h3C, 1, 17, 0, 4'h0);
    expect_write(n0, 32'hFF80_0010, 8'h3C, 1'b0);

    // R3: bit 0 of the type nibble has no effect
    tag = "R3 type bit0";
    n0 = nstrobe;
    lpc_write(4'b0111, 32'hFFFF_FFFF, 8'h00, 1, 17, 0, 4'h0);
    expect_write(n0, 32'hFFFF_FFFF, 8'h00, 1'b1);

    // R3: read and foreign types are ignored
    tag = "R3 bad type";
    n0 = nstrobe; o0 = noe;
    lpc_write(4'b0100, 32'hFFC0_0000, 8'h11, 1, 17, 0, 4'h0);
    lpc_write(4'b1110, 32'hFFC0_0000, 8'h22, 1, 17, 0, 4'h0);
    chk(nstrobe == n0, "no strobe", 32'(nstrobe), 32'(n0));
    chk(noe == o0, "no drive", 32'(noe), 32'(o0));

    // R5: prefix mismatch
    tag = "R5 prefix";
    n0 = nstrobe; o0 = noe;
    lpc_write(4'b0110, 32'hFF7F_FFFF, 8'h33, 1, 17, 0, 4'h0);
    lpc_write(4'b0110, 32'h7FC0_0000, 8'h44, 1, 17, 0, 4'h0);
    chk(nstrobe == n0, "no strobe", 32'(nstrobe), 32'(n0));
    chk(noe == o0, "no drive", 32'(noe), 32'(o0));

    // R2: no start without frame low, nor with a non-zero nibble
    tag = "R2 start";
    n0 = nstrobe;
    slot(1'b1, 4'h0);
    lpc_write(4'b0110, 32'hFFC0_0001, 8'h55, 2, 17, 0, 4'h0);
    slot(1'b0, 4'h5);
    slot(1'b0, 4'h5);
    lpc_write(4'b0110, 32'hFFC0_0001, 8'h55, 2, 17, 0, 4'h0);
    chk(nstrobe == n0, "no start", 32'(nstrobe), 32'(n0));
    slot(1'b0, 4'h5);
    lpc_write(4'b0110, 32'hFFC0_0002, 8'h66, 1, 17, 0, 4'h0);
    expect_write(n0, 32'hFFC0_0002, 8'h66, 1'b1);

    // R11: abort mid address, then abort with a restart
    tag = "R11 abort";
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFFC0_1234, 8'h77, 1, 17, 6, 4'hF);
    idle(12);
    chk(nstrobe == n0, "abort no strobe", 32'(nstrobe), 32'(n0));
    lpc_write(4'b0110, 32'hFFC0_1234, 8'h77, 1, 17, 9, 4'h0);
    lpc_write(4'b0110, 32'hFFD0_5678, 8'h88, 2, 17, 0, 4'h0);
    expect_write(n0, 32'hFFD0_5678, 8'h88, 1'b1);
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFFC0_9999, 8'h99, 1, 17, 14, 4'hF);
    idle(4);
    chk(nstrobe == n0, "late abort no strobe", 32'(nstrobe), 32'(n0));

    // R8 R9 R10: step through the handshake clock by clock
    tag = "R8 handshake";
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFFC0_00AB, 8'hCD, 1, 13, 0, 4'h0);
    chk(lad_oe === 1'b0, "oe before edge 13", 32'(lad_oe), 0);
    @(negedge clk);
    chk(lad_oe === 1'b1 && lad_out === 4'hF, "clock 14", {lad_oe, lad_out}, 32'h1F);
    lframe_n = 1'b1; lad_in = 4'hF;
    tag = "R9 sync";
    @(negedge clk);
    chk(lad_oe === 1'b1 && lad_out === 4'h0 && wr_valid === 1'b1, "clock 15",
        {wr_valid, lad_oe, lad_out}, 32'h30);
    tag = "R10 release";
    @(negedge clk);
    chk(lad_oe === 1'b1 && lad_out === 4'hF && wr_valid === 1'b0, "clock 16",
        {wr_valid, lad_oe, lad_out}, 32'h1F);
    @(negedge clk);
    chk(lad_oe === 1'b0, "clock 17", 32'(lad_oe), 0);
    expect_write(n0, 32'hFFC0_00AB, 8'hCD, 1'b1);

    // R10: back-to-back, next start sampled at edge 17
    tag = "R10 back-to-back";
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFFC0_0F0F, 8'h12, 1, 16, 0, 4'h0);
    lpc_write(4'b0110, 32'hFF80_F0F0, 8'h34, 1, 17, 0, 4'h0);
    expect_write(n0 + 1, 32'hFF80_F0F0, 8'h34, 1'b0);

    // R1: reset in the middle of the handshake
    tag = "R1 mid reset";
    n0 = nstrobe;
    lpc_write(4'b0110, 32'hFFC0_0000, 8'h56, 1, 13, 0, 4'h0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(lad_oe === 1'b0 && wr_valid === 1'b0, "reset drops drive",
        {lad_oe, wr_valid}, 0);
    rst_n = 1'b1;
    idle(3);
    chk(nstrobe == n0, "no strobe after reset", 32'(nstrobe), 32'(n0));

    running = 1'b0;
    finish_up();
  end

endmodule